// File: doc/BRIEF.md
# Cosine Soft Mute Ramp

This block sits in a stereo PCM output path and removes the click that an abrupt start or stop of the signal would cause. When the path is switched off, a shutdown request fades the common left/right gain from unity to silence along a raised-cosine curve. A start-up request lifts the gain from silence back to unity along the mirror image of that curve. The curve is coarse: 32 gain levels, each held for 4 sample periods, so a full fade takes 128 sample periods.

The step counter moves only on the sample-rate strobe, so the fade time follows the sample rate, including double-speed operation. An opposite request during a fade turns the fade around at the current level, with no jump. Both channels are multiplied by the same gain, rounded and saturated, and registered on the strobe. After reset the block is silent and waits for the first start-up request.

Top module: `soft_mute_ramp`

## Requirements
- R1: After reset `muted`=1 and `busy`=0, both outputs are 0, and samples taken by a strobe while muted produce 0.
- R2: A shutdown request (`pwr_dn_req`) accepted at unity gain starts a fade in which the n-th following strobe (n=0..127) scales with table level n/4 (integer division). The 128th strobe ends it at gain 0 with `muted`=1 and `busy`=0.
- R3: A start-up request (`pwr_up_req`) accepted at silence starts a fade in which the n-th strobe uses level 32-n/4, where level 32 means gain 0. After 128 strobes the gain is unity and `busy`=0.
- R4: Gain is unsigned Q1.15, with unity = 32768. Level k (0..31) is round(32768·0.5·(1+cos(πk/32))) and level 32 is exactly 0.
- R5: The level and its hold count change only on a strobe. Clock cycles without a strobe leave the gain and the outputs unchanged.
- R6: An opposite request during a fade reverses the direction from the current level without changing it, and restarts the 4-strobe hold at that level.
- R7: When both requests are high together, shutdown has priority. A request is ignored, with `busy` staying 0, when the gain is already at its target. A request in the direction already being faded is also ignored.
- R8: On a cycle where a request is accepted together with a strobe, that strobe is scaled with the level in force before the request. It does not count toward the 128.
- R9: On each strobe, each output takes sat24((x·g + 2^14) >>> 15) of its own input, using the same gain g for both channels. The result appears one clock after the strobe and is held until the next strobe.
- R10: `busy` is high from the clock after an accepted request until the clock after the fade's last strobe. `muted` is high exactly when the gain is 0 and no fade is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | One-cycle strobe per sample period |
| pwr_up_req | input | 1 | Start-up (fade-in) request |
| pwr_dn_req | input | 1 | Shutdown (fade-out) request |
| left_in | input | SAMPLE_W | Left sample, signed |
| right_in | input | SAMPLE_W | Right sample, signed |
| left_out | output | SAMPLE_W | Scaled left sample, signed |
| right_out | output | SAMPLE_W | Scaled right sample, signed |
| muted | output | 1 | Gain is zero and idle |
| busy | output | 1 | A fade is in progress |

## Verification
Two pairs of functions can fall in the same clock: the acceptance of a request and the scaling of a sample strobe, and the two opposite requests. The bench drives a shutdown request in the same cycle as a strobe. It expects that strobe to be scaled with the old gain and the fade to still take exactly 128 later strobes. It also raises both requests at once in the middle of a fade-in and expects a reversal toward silence. A reference model built from the requirements predicts every output sample and flag, while the strobes arrive at random spacing.

// File: rtl/smr_pkg.sv
package smr_pkg;

   typedef enum logic {
      DIR_UP = 1'b0,
      DIR_DN = 1'b1
   } ramp_dir_e;

endpackage

// File: rtl/smr_step_ctrl.sv
module smr_step_ctrl
   import smr_pkg::*;
#(
   parameter int STEPS = 32,
   parameter int HOLD  = 4,
   localparam int POS_W = $clog2(STEPS + 1),
   localparam int CNT_W = $clog2(HOLD)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb,
   input  logic             up_req,
   input  logic             dn_req,
   output logic [POS_W-1:0] pos,
   output logic             ramp_busy
);

   localparam logic [POS_W-1:0] POS_MUTE  = POS_W'(STEPS);
   localparam logic [POS_W-1:0] POS_UNITY = '0;
   localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(HOLD - 1);

   generate
      if (HOLD < 2) begin : g_bad_hold
         $error("HOLD must be at least 2");
      end
      if (STEPS < 2) begin : g_bad_steps
         $error("STEPS must be at least 2");
      end
   endgenerate

   ramp_dir_e        dir;
   logic [CNT_W-1:0] cnt;
   logic             dn_ok, up_ok, start, hold_done, reach_end;
   logic [POS_W-1:0] pos_nxt;

   always_comb begin
      dn_ok     = dn_req && (pos != POS_MUTE) && !(ramp_busy && dir == DIR_DN);
      up_ok     = !dn_req && up_req && (pos != POS_UNITY) &&
                  !(ramp_busy && dir == DIR_UP);
      start     = dn_ok || up_ok;
      hold_done = (cnt == CNT_LAST);
      pos_nxt   = (dir == DIR_DN) ? pos + POS_W'(1) : pos - POS_W'(1);
      reach_end = (dir == DIR_DN) ? (pos_nxt == POS_MUTE) : (pos_nxt == POS_UNITY);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos       <= POS_MUTE;
         cnt       <= '0;
         dir       <= DIR_UP;
         ramp_busy <= 1'b0;
      end else if (start) begin
         ramp_busy <= 1'b1;
         dir       <= dn_ok ? DIR_DN : DIR_UP;
         cnt       <= '0;
      end else if (ramp_busy && stb) begin
         if (hold_done) begin
            cnt <= '0;
            pos <= pos_nxt;
            if (reach_end) ramp_busy <= 1'b0;
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end

   // R5
   step_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pos != $past(pos)) |-> $past(stb));

   // R6
   step_no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pos != $past(pos)) |-> ((pos == $past(pos) + POS_W'(1)) ||
                               (pos + POS_W'(1) == $past(pos))));

   // R10
   end_at_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ramp_busy) |-> ((pos == POS_UNITY) || (pos == POS_MUTE)));

   // R7
   ignore_at_unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ramp_busy && pos == POS_UNITY && up_req && !dn_req) |=> !ramp_busy);

endmodule

// File: rtl/smr_gain_rom.sv
module smr_gain_rom #(
   parameter int STEPS  = 32,
   parameter int GAIN_W = 16,
   localparam int POS_W = $clog2(STEPS + 1),
   localparam int IDX_W = $clog2(STEPS)
) (
   input  logic [POS_W-1:0]  pos,
   output logic [GAIN_W-1:0] gain
);

   generate
      if (STEPS != 32 || GAIN_W != 16) begin : g_bad_shape
         $error("cosine table is built for 32 levels of 16 bits");
      end
   endgenerate

   // raised-cosine levels, Q1.15, level 0 = unity
   localparam logic [15:0] COS_TAB [32] = '{
      16'd32768, 16'd32689, 16'd32453, 16'd32063,
      16'd31521, 16'd30833, 16'd30007, 16'd29049,
      16'd27969, 16'd26778, 16'd25486, 16'd24107,
      16'd22654, 16'd21140, 16'd19580, 16'd17990,
      16'd16384, 16'd14778, 16'd13188, 16'd11628,
      16'd10114, 16'd8661,  16'd7282,  16'd5990,
      16'd4799,  16'd3719,  16'd2761,  16'd1935,
      16'd1247,  16'd705,   16'd315,   16'd79
   };

   always_comb begin
      if (pos >= POS_W'(STEPS)) gain = '0;
      else                      gain = GAIN_W'(COS_TAB[pos[IDX_W-1:0]]);
   end

endmodule

// File: rtl/smr_scaler.sv
module smr_scaler #(
   parameter int SAMPLE_W = 24,
   parameter int GAIN_W   = 16,
   localparam int FRAC    = GAIN_W - 1,
   localparam int PW      = SAMPLE_W + GAIN_W + 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       stb,
   input  logic [GAIN_W-1:0]          gain,
   input  logic signed [SAMPLE_W-1:0] x,
   output logic signed [SAMPLE_W-1:0] y
);

   localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);
   localparam logic signed [PW-1:0] HI   = (PW'(1) <<< (SAMPLE_W - 1)) - PW'(1);
   localparam logic signed [PW-1:0] LO   = -(PW'(1) <<< (SAMPLE_W - 1));

   logic signed [PW-1:0]       prod, biased, shifted;
   logic signed [SAMPLE_W-1:0] sat;

   always_comb begin
      prod    = PW'(x) * $signed({1'b0, gain});
      biased  = prod + HALF;
      shifted = biased >>> FRAC;
      if (shifted > HI)      sat = HI[SAMPLE_W-1:0];
      else if (shifted < LO) sat = LO[SAMPLE_W-1:0];
      else                   sat = shifted[SAMPLE_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   y <= '0;
      else if (stb) y <= sat;
   end

   // R9
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(stb) |-> $stable(y));

endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp
   import smr_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int GAIN_W   = 16,
   parameter int STEPS    = 32,
   parameter int HOLD     = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       smp_stb,
   input  logic                       pwr_up_req,
   input  logic                       pwr_dn_req,
   input  logic signed [SAMPLE_W-1:0] left_in,
   input  logic signed [SAMPLE_W-1:0] right_in,
   output logic signed [SAMPLE_W-1:0] left_out,
   output logic signed [SAMPLE_W-1:0] right_out,
   output logic                       muted,
   output logic                       busy
);

   localparam int NCH   = 2;
   localparam int POS_W = $clog2(STEPS + 1);

   logic [POS_W-1:0]           pos;
   logic [GAIN_W-1:0]          gain;
   logic signed [SAMPLE_W-1:0] ch_in  [NCH];
   logic signed [SAMPLE_W-1:0] ch_out [NCH];

   smr_step_ctrl #(.STEPS(STEPS), .HOLD(HOLD)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb       (smp_stb),
      .up_req    (pwr_up_req),
      .dn_req    (pwr_dn_req),
      .pos       (pos),
      .ramp_busy (busy)
   );

   smr_gain_rom #(.STEPS(STEPS), .GAIN_W(GAIN_W)) u_rom (
      .pos  (pos),
      .gain (gain)
   );

   assign ch_in[0] = left_in;
   assign ch_in[1] = right_in;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         smr_scaler #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_scl (
            .clk   (clk),
            .rst_n (rst_n),
            .stb   (smp_stb),
            .gain  (gain),
            .x     (ch_in[c]),
            .y     (ch_out[c])
         );
      end
   endgenerate

   assign left_out  = ch_out[0];
   assign right_out = ch_out[1];
   assign muted     = (pos == POS_W'(STEPS)) && !busy;

   // R1
   muted_zero_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      muted |-> (gain == '0));

   // R4
   unity_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pos == '0) |-> (gain == GAIN_W'(1 << (GAIN_W - 1))));

endmodule

// File: tb/soft_mute_ramp_tb_top.sv
module soft_mute_ramp_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stb = 1'b0, up = 1'b0, dn = 1'b0;
   logic signed [23:0] lin = '0, rin = '0;
   logic signed [23:0] lout, rout;
   logic muted, busy;

   int checks = 0;
   int fails  = 0;

   int mpos = 32, mcnt = 0, ramp_stb = 0;
   bit mbusy = 1'b0, mdn = 1'b0;
   logic signed [23:0] el = '0, er = '0;

   always #10 clk = ~clk;

   soft_mute_ramp dut_i (
      .clk(clk), .rst_n(rst_n), .smp_stb(stb), .pwr_up_req(up), .pwr_dn_req(dn),
      .left_in(lin), .right_in(rin), .left_out(lout), .right_out(rout),
      .muted(muted), .busy(busy)
   );

   function automatic int gexp(int p);
      real v;
      if (p >= 32) return 0;
      v = 16384.0 * (1.0 + $cos(3.141592653589793 * p / 32.0));
      return int'($floor(v + 0.5));
   endfunction

   function automatic logic signed [23:0] scale(logic signed [23:0] x, int g);
      longint p;
      p = (longint'(x) * longint'(g) + 64'sd16384) >>> 15;
      if (p > 64'sd8388607)  p = 64'sd8388607;
      if (p < -64'sd8388608) p = -64'sd8388608;
      return p[23:0];
   endfunction

   task automatic chk(bit ok, string tag, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // one clock: drive at negedge, update model, check at next negedge
   task automatic tick(bit s, bit u, bit d, logic signed [23:0] l,
                       logic signed [23:0] r, string tag);
      bit dn_ok, up_ok;
      stb = s; up = u; dn = d; lin = l; rin = r;
      if (s) begin
         el = scale(l, gexp(mpos));
         er = scale(r, gexp(mpos));
      end
      dn_ok = d && mpos != 32 && !(mbusy && mdn);
      up_ok = !d && u && mpos != 0 && !(mbusy && !mdn);
      if (dn_ok || up_ok) begin
         mbusy = 1'b1; mdn = dn_ok; mcnt = 0; ramp_stb = 0;
      end else if (mbusy && s) begin
         ramp_stb++;
         if (mcnt == 3) begin
            mcnt = 0;
            mpos = mdn ? mpos + 1 : mpos - 1;
            if (mpos == 0 || mpos == 32) mbusy = 1'b0;
         end else mcnt++;
      end
      @(negedge clk);
      chk(lout == el, tag, "left_out", lout, el);
      chk(rout == er, tag, "right_out", rout, er);
      chk(busy == mbusy, tag, "busy", busy, mbusy);
      chk(muted == (mpos == 32 && !mbusy), tag, "muted", muted, (mpos == 32 && !mbusy));
   endtask

   function automatic logic signed [23:0] rs();
      return 24'($urandom);
   endfunction

   task automatic run_rand(int n, string tag);
      for (int i = 0; i < n; i++)
         tick($urandom % 2 == 0, 1'b0, 1'b0, rs(), rs(), tag);
   endtask

   task automatic run_done(string tag);
      int guard = 0;
      while (mbusy && guard < 2000) begin
         tick($urandom % 3 != 0, 1'b0, 1'b0, rs(), rs(), tag);
         guard++;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd7719));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(muted == 1'b1, "R1", "muted", muted, 1);
      chk(busy == 1'b0, "R1", "busy", busy, 0);
      chk(lout == 0 && rout == 0, "R1", "outputs", lout, 0);
      rst_n = 1'b1;
      // R1/R4: strobes while muted give zero
      tick(1, 0, 0, 24'sd8388607, -24'sd8388608, "R1");
      tick(1, 0, 0, rs(), rs(), "R1");
      // R3: fade in with random strobe spacing (R5 idle cycles)
      tick(0, 1, 0, rs(), rs(), "R3");
      run_done("R3");
      chk(ramp_stb == 128, "R3", "strobes in fade", ramp_stb, 128);
      // R9: extremes at unity
      tick(1, 0, 0, 24'sd8388607, -24'sd8388608, "R9");
      tick(1, 0, 0, -24'sd1, 24'sd1, "R9");
      tick(0, 0, 0, rs(), rs(), "R5");
      // R7: start-up at unity ignored
      tick(1, 1, 0, rs(), rs(), "R7");
      // R8: shutdown coinciding with strobe, R2 fade out
      tick(1, 0, 1, 24'sd4000000, -24'sd4000000, "R8");
      run_done("R2");
      chk(ramp_stb == 128, "R2", "strobes in fade", ramp_stb, 128);
      // R7: shutdown while muted ignored
      tick(1, 0, 1, rs(), rs(), "R7");
      // R6/R7: fade in, then both requests mid-fade -> reverse down
      tick(0, 1, 0, rs(), rs(), "R6");
      run_rand(60 + int'($urandom % 50), "R6");
      tick(1, 1, 1, rs(), rs(), "R7");
      chk(mdn == 1'b1, "R7", "model dir", mdn, 1);
      run_rand(20 + int'($urandom % 20), "R6");
      // R6: reverse again upward, repeated request in same direction ignored
      tick(0, 1, 0, rs(), rs(), "R6");
      tick(1, 1, 0, rs(), rs(), "R7");
      run_done("R6");
      chk(mpos == 0, "R6", "ends at unity", mpos, 0);
      tick(1, 0, 0, 24'sd1234567, -24'sd7654321, "R9");
      // R10: full fade out with a strobe every cycle
      tick(0, 0, 1, rs(), rs(), "R10");
      for (int i = 0; i < 128; i++) tick(1, 0, 0, rs(), rs(), "R10");
      chk(muted == 1'b1 && busy == 1'b0, "R10", "done flags", muted, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule